// File: doc/BRIEF.md
# Dual-Rate Power-of-Two Decimation Chain

This block takes a set of simultaneously sampled 16-bit signed channels, one new sample per channel on each input strobe, and runs every channel through one cascade of halving stages. Each stage is a small low-pass filter followed by a keep-one-of-two decimation. A single sequencer walks the channels and stages one step per clock, so one adder tree serves all of them inside the clock budget of one input period. The filter history for each channel and stage sits in a small indexed store.

Two output taps read the cascade at different depths. The fast tap reads stage N (0 to 6, stage 0 being the raw input), giving the input rate divided by 2^N. The slow tap starts three halvings down, at one eighth of the input rate, and reads stage 3+N for N from 0 to 14. Both taps share the same stages, so the slow path costs no extra arithmetic. Each tap presents all channels side by side on one bus, with one valid strobe per output instant.

Top module: `pow2_decim_chain`

## Requirements
- R1: After reset both valid strobes are low, both data buses are zero, the sample index is zero and all filter history is zero.
- R2: The fast tap with rate code N asserts `fastVld` after input sample s (counted from 0 after reset) exactly when the N low bits of s are all one, so once every 2^N samples. With N=0 it fires on every sample and carries the input unchanged.
- R3: The slow tap with rate code N reads stage 3+N and asserts `slowVld` after sample s exactly when the 3+N low bits of s are all one, so once every 8*2^N samples.
- R4: Each halving stage k takes its input from the outputs of stage k-1 and computes y = floor((x0 + 2*x1 + x2 + 2) / 4), where x0 is the newest input and x1, x2 are the two before it. It keeps one output per two inputs: the one computed when the newest input's index is odd.
- R5: A fast rate code above 6 behaves as 6, and a slow rate code above 14 behaves as 14.
- R6: A sample strobe that arrives while a walk is in progress is ignored: the cascade neither advances nor restarts.
- R7: Channel c sits at bits [16c+15:16c] of each data bus. All channels of one instant share one valid strobe, and a data bus changes only in a cycle where its valid strobe is high.
- R8: Each valid strobe is a one-cycle pulse, and it appears within `CYC_PER_SAMPLE` clocks of the accepted sample strobe.
- R9: A rate code is taken when a sample is accepted. Changing it changes only which stage a tap reads, not the cascade's contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | One-cycle strobe: a new simultaneous sample is on `sampleIn` |
| sampleIn | input | NCH*16 | Signed samples, channel c at bits [16c+15:16c] |
| fastRate | input | AR_W | Fast tap rate code N |
| slowRate | input | DR_W | Slow tap rate code N |
| fastData | output | NCH*16 | Fast tap samples, one 16-bit lane per channel |
| fastVld | output | 1 | Fast tap valid pulse |
| slowData | output | NCH*16 | Slow tap samples, one 16-bit lane per channel |
| slowVld | output | 1 | Slow tap valid pulse |

## Verification
The assertions check on every cycle that the sequencer steps through stages in ascending order, that a strobe during a walk neither restarts nor advances it, that a walk stays within the cycle budget, and that each output strobe is a single-cycle pulse with its data bus still outside that pulse. Only the bench's scenarios can show the filter's numbers, including floor rounding at the full-scale extremes, and the exact firing pattern of each tap for each rate code. The same holds for the clamping of oversized rate codes and for the cascade carrying on unaffected when the rates change between runs.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int CHAN_W = 5;
  localparam int STG_W  = 5;

  typedef struct packed {
    logic              load;
    logic              step;
    logic [CHAN_W-1:0] chan;
    logic [STG_W-1:0]  stg;
    logic              rcv;
    logic              prod;
    logic              tapFast;
    logic              tapSlow;
    logic              done;
    logic              fastFire;
    logic              slowFire;
  } seqCtl_t;
endpackage

// File: rtl/decim_ctl.sv
module decim_ctl
  import decim_pkg::*;
#(
  parameter int NCH            = 6,
  parameter int FAST_MAX       = 6,
  parameter int SLOW_OFF       = 3,
  parameter int SLOW_MAX       = 14,
  parameter int CYC_PER_SAMPLE = 128,
  localparam int NSTG = SLOW_OFF + SLOW_MAX,
  localparam int AR_W = $clog2(FAST_MAX + 1),
  localparam int DR_W = $clog2(SLOW_MAX + 1),
  localparam int CC_W = $clog2(CYC_PER_SAMPLE + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleStb,
  input  logic [AR_W-1:0] fastRate,
  input  logic [DR_W-1:0] slowRate,
  output seqCtl_t         ctl
);
  logic              busy, doneQ, fastFire, slowFire;
  logic [CHAN_W-1:0] chan;
  logic [STG_W-1:0]  stg, fastStg, slowStg;
  logic [NSTG-1:0]   sIdx;
  logic [CC_W-1:0]   cyc;
  logic              lastStep, accept;
  int                fastN, slowN;

  function automatic logic lowOnes(input logic [NSTG-1:0] v, input int n);
    logic r;
    r = 1'b1;
    for (int i = 0; i < NSTG; i++)
      if (i < n && !v[i]) r = 1'b0;
    return r;
  endfunction

  always_comb begin
    fastN    = (int'(fastRate) > FAST_MAX) ? FAST_MAX : int'(fastRate);
    slowN    = ((int'(slowRate) > SLOW_MAX) ? SLOW_MAX : int'(slowRate)) + SLOW_OFF;
    lastStep = busy && (int'(chan) == NCH - 1) && (int'(stg) == NSTG);
    accept   = sampleStb && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; doneQ <= 1'b0; fastFire <= 1'b0; slowFire <= 1'b0;
      chan <= '0; stg <= '0; fastStg <= '0; slowStg <= '0; sIdx <= '0; cyc <= '0;
    end else begin
      doneQ <= lastStep;
      if (accept) begin
        busy     <= 1'b1;
        chan     <= '0;
        stg      <= '0;
        cyc      <= '0;
        fastStg  <= STG_W'(fastN);
        slowStg  <= STG_W'(slowN);
        fastFire <= lowOnes(sIdx, fastN);
        slowFire <= lowOnes(sIdx, slowN);
      end else if (busy) begin
        cyc <= cyc + 1'b1;
        if (lastStep) begin
          busy <= 1'b0;
          chan <= '0;
          stg  <= '0;
          sIdx <= sIdx + 1'b1;
        end else if (int'(stg) == NSTG) begin
          stg  <= '0;
          chan <= chan + 1'b1;
        end else begin
          stg <= stg + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.load     = accept;
    ctl.step     = busy;
    ctl.chan     = chan;
    ctl.stg      = stg;
    ctl.rcv      = (stg == '0) ? 1'b1 : lowOnes(sIdx, int'(stg) - 1);
    ctl.prod     = lowOnes(sIdx, int'(stg));
    ctl.tapFast  = (stg == fastStg);
    ctl.tapSlow  = (stg == slowStg);
    ctl.done     = doneQ;
    ctl.fastFire = fastFire;
    ctl.slowFire = slowFire;
  end

  AST_STB_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sampleStb && !lastStep) |=> (busy && ({chan, stg} != '0) && $stable(sIdx))); // R6
  AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (busy && int'(stg) != NSTG) |=> (int'(stg) == int'($past(stg)) + 1)); // R4
  AST_WALK_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(cyc) < CYC_PER_SAMPLE)); // R8
endmodule

// File: rtl/decim_dp.sv
module decim_dp
  import decim_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int NSTG = 17,
  localparam int DW   = 16,
  localparam int NENT = NCH * (NSTG + 1),
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CIW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [NCH*DW-1:0] sampleIn,
  output logic [NCH*DW-1:0] fastData,
  output logic              fastVld,
  output logic [NCH*DW-1:0] slowData,
  output logic              slowVld
);
  logic signed [DW-1:0]   inReg [NCH];
  logic signed [DW-1:0]   histNew [NENT];
  logic signed [DW-1:0]   histOld [NENT];
  logic signed [DW-1:0]   fastHold [NCH];
  logic signed [DW-1:0]   slowHold [NCH];
  logic signed [DW-1:0]   carry, p1, p2, y, stepOut;
  logic signed [DW+1:0]   acc;
  logic [IW-1:0]          idx;
  logic [CIW-1:0]         chanI;

  always_comb begin
    chanI   = CIW'(ctl.chan);
    idx     = IW'(int'(ctl.chan) * (NSTG + 1) + int'(ctl.stg));
    p1      = histNew[idx];
    p2      = histOld[idx];
    acc     = (DW+2)'(carry) + ((DW+2)'(p1) <<< 1) + (DW+2)'(p2) + (DW+2)'(2);
    y       = acc[DW+1:2];
    stepOut = (ctl.stg == '0) ? inReg[chanI] : y;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NENT; e++) begin
        histNew[e] <= '0;
        histOld[e] <= '0;
      end
      for (int c = 0; c < NCH; c++) begin
        inReg[c] <= '0; fastHold[c] <= '0; slowHold[c] <= '0;
      end
      carry <= '0;
      fastData <= '0; slowData <= '0; fastVld <= 1'b0; slowVld <= 1'b0;
    end else begin
      fastVld <= 1'b0;
      slowVld <= 1'b0;
      if (ctl.load)
        for (int c = 0; c < NCH; c++) inReg[c] <= sampleIn[c*DW +: DW];
      if (ctl.step) begin
        carry <= stepOut;
        if (ctl.stg != '0 && ctl.rcv) begin
          histNew[idx] <= carry;
          histOld[idx] <= p1;
        end
        if (ctl.prod && ctl.tapFast) fastHold[chanI] <= stepOut;
        if (ctl.prod && ctl.tapSlow) slowHold[chanI] <= stepOut;
      end
      if (ctl.done) begin
        if (ctl.fastFire) begin
          fastVld <= 1'b1;
          for (int c = 0; c < NCH; c++) fastData[c*DW +: DW] <= fastHold[c];
        end
        if (ctl.slowFire) begin
          slowVld <= 1'b1;
          for (int c = 0; c < NCH; c++) slowData[c*DW +: DW] <= slowHold[c];
        end
      end
    end
  end

  AST_FAST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fastVld |=> !fastVld); // R8
  AST_SLOW_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    slowVld |=> !slowVld); // R8
  AST_FAST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fastVld |-> $stable(fastData)); // R7
  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !slowVld |-> $stable(slowData)); // R7
endmodule

// File: rtl/pow2_decim_chain.sv
module pow2_decim_chain
  import decim_pkg::*;
#(
  parameter int NCH            = 6,
  parameter int FAST_MAX       = 6,
  parameter int SLOW_OFF       = 3,
  parameter int SLOW_MAX       = 14,
  parameter int CYC_PER_SAMPLE = 128,
  localparam int NSTG = SLOW_OFF + SLOW_MAX,
  localparam int AR_W = $clog2(FAST_MAX + 1),
  localparam int DR_W = $clog2(SLOW_MAX + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleStb,
  input  logic [NCH*16-1:0] sampleIn,
  input  logic [AR_W-1:0] fastRate,
  input  logic [DR_W-1:0] slowRate,
  output logic [NCH*16-1:0] fastData,
  output logic            fastVld,
  output logic [NCH*16-1:0] slowData,
  output logic            slowVld
);
  seqCtl_t ctl;

  decim_ctl #(
    .NCH(NCH), .FAST_MAX(FAST_MAX), .SLOW_OFF(SLOW_OFF),
    .SLOW_MAX(SLOW_MAX), .CYC_PER_SAMPLE(CYC_PER_SAMPLE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb),
    .fastRate(fastRate), .slowRate(slowRate), .ctl(ctl)
  );

  decim_dp #(.NCH(NCH), .NSTG(NSTG)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .fastData(fastData), .fastVld(fastVld),
    .slowData(slowData), .slowVld(slowVld)
  );
endmodule

// File: tb/sim_pow2_decim_chain.sv
module sim_pow2_decim_chain;
  localparam int NCH  = 2;
  localparam int CYC  = 64;
  localparam int NSTG = 17;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleStb = 1'b0;
  logic [NCH*16-1:0] sampleIn = '0;
  logic [2:0]        fastRate = '0;
  logic [3:0]        slowRate = '0;
  logic [NCH*16-1:0] fastData, slowData;
  logic              fastVld, slowVld;

  always #5 clk = ~clk;

  pow2_decim_chain #(.NCH(NCH), .CYC_PER_SAMPLE(CYC)) u0 (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .sampleIn(sampleIn),
    .fastRate(fastRate), .slowRate(slowRate),
    .fastData(fastData), .fastVld(fastVld),
    .slowData(slowData), .slowVld(slowVld)
  );

  // fastRate, slowRate, samples, pattern, expected fast pulses, expected slow pulses
  localparam int VEC [5][6] = '{
    '{0, 0, 32, 0, 32, 4},
    '{2, 1, 32, 1,  8, 2},
    '{6, 2, 64, 0,  1, 2},
    '{7, 15, 64, 2, 1, 0},
    '{1, 0, 32, 0, 16, 4}
  };

  int total = 0, fails = 0, sIdx = 0, pat = 0;
  int mh1 [NCH][NSTG+1];
  int mh2 [NCH][NSTG+1];
  int mst [NCH][NSTG+1];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stim(input int s, input int c);
    if (pat == 1) return ((s + c) % 2 == 0) ? 32767 : -32768;
    if (pat == 2) return -1 - c;
    return int'($signed(16'((s * 2371 + c * 9973 + s * s * 17) ^ (s << 3))));
  endfunction

  function automatic bit lowOnes(input int s, input int n);
    return (s & ((1 << n) - 1)) == ((1 << n) - 1);
  endfunction

  task automatic modelStep(input int s);
    for (int c = 0; c < NCH; c++) begin
      int v, yv;
      v = stim(s, c);
      mst[c][0] = v;
      for (int k = 1; k <= NSTG; k++) begin
        if (!lowOnes(s, k - 1)) break;
        yv = (v + 2 * mh1[c][k] + mh2[c][k] + 2) >>> 2;
        mh2[c][k] = mh1[c][k];
        mh1[c][k] = v;
        if (!lowOnes(s, k)) break;
        mst[c][k] = yv;
        v = yv;
      end
    end
  endtask

  task automatic doSample(input bit extraStb, output int nFast, output int nSlow);
    int fT, sT, fSeen, sSeen;
    logic [NCH*16-1:0] prevF, prevS;
    fT = (int'(fastRate) > 6) ? 6 : int'(fastRate);
    sT = ((int'(slowRate) > 14) ? 14 : int'(slowRate)) + 3;
    for (int c = 0; c < NCH; c++) sampleIn[c*16 +: 16] = 16'(stim(sIdx, c));
    prevF = fastData; prevS = slowData;
    @(negedge clk) sampleStb = 1'b1;
    @(negedge clk) sampleStb = 1'b0;
    modelStep(sIdx);
    fSeen = 0; sSeen = 0;
    for (int i = 0; i < CYC; i++) begin
      if (extraStb && i == 4) sampleStb = 1'b1;
      if (i == 5) sampleStb = 1'b0;
      if (fastVld) begin
        fSeen++;
        for (int c = 0; c < NCH; c++)
          chk(fastData[c*16 +: 16] == 16'(mst[c][fT]), "R4 R2 fast data",
              int'($signed(fastData[c*16 +: 16])), mst[c][fT]);
      end else if (fastData != prevF)
        chk(1'b0, "R7 fast bus changed without pulse", 0, 0);
      if (slowVld) begin
        sSeen++;
        for (int c = 0; c < NCH; c++)
          chk(slowData[c*16 +: 16] == 16'(mst[c][sT]), "R4 R3 slow data",
              int'($signed(slowData[c*16 +: 16])), mst[c][sT]);
      end else if (slowData != prevS)
        chk(1'b0, "R7 slow bus changed without pulse", 0, 0);
      prevF = fastData; prevS = slowData;
      @(negedge clk);
    end
    chk(fSeen == int'(lowOnes(sIdx, fT)), "R2 R8 fast pulse per sample", fSeen, int'(lowOnes(sIdx, fT)));
    chk(sSeen == int'(lowOnes(sIdx, sT)), "R3 R8 slow pulse per sample", sSeen, int'(lowOnes(sIdx, sT)));
    nFast = fSeen; nSlow = sSeen;
    sIdx++;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int nf, ns, cf, cs;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k <= NSTG; k++) begin
        mh1[c][k] = 0; mh2[c][k] = 0; mst[c][k] = 0;
      end
    repeat (3) @(negedge clk);
    chk(fastVld == 1'b0 && slowVld == 1'b0, "R1 strobes low in reset", int'(fastVld) + int'(slowVld), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(fastData == '0, "R1 fast bus zero", int'(fastData), 0);
    chk(slowData == '0, "R1 slow bus zero", int'(slowData), 0);

    // R5 R9: table walk, rates change between rows while the cascade runs on
    for (int v = 0; v < 5; v++) begin
      fastRate = 3'(VEC[v][0]);
      slowRate = 4'(VEC[v][1]);
      pat = VEC[v][3];
      cf = 0; cs = 0;
      for (int n = 0; n < VEC[v][2]; n++) begin
        doSample(1'b0, nf, ns);
        cf += nf; cs += ns;
      end
      chk(cf == VEC[v][4], "R2 R5 R9 fast pulse count", cf, VEC[v][4]);
      chk(cs == VEC[v][5], "R3 R5 R9 slow pulse count", cs, VEC[v][5]);
    end

    // R6: extra strobe inside each walk must not advance the cascade
    fastRate = 3'd3; slowRate = 4'd0; pat = 0;
    cf = 0; cs = 0;
    for (int n = 0; n < 16; n++) begin
      doSample(1'b1, nf, ns);
      cf += nf; cs += ns;
    end
    chk(cf == 2, "R6 fast count with stray strobes", cf, 2);
    chk(cs == 2, "R6 slow count with stray strobes", cs, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule